// File: doc/BRIEF.md
# Dual-Length Parallel FIR Filter

This block is a fully parallel FIR filter. It runs at one of two lengths, chosen while it operates: the full length of N taps, or the half length of N/2 taps. N multipliers are arranged in two rows of N/2. Each row feeds a pair of adder trees. One tree sums the products that carry even-index coefficients and the other sums those that carry odd-index coefficients. A single serial sample stream enters with a valid strobe. Coefficients are loaded through a simple write port, one signed word per cycle, where the address is the coefficient index k of h(k).

In full-length mode, each accepted sample runs the whole N-tap convolution in one pass. In half-length mode, a one-sample pairing stage groups the stream into pairs. Each pair shifts both delay lines by two positions. The same multipliers then produce two consecutive half-length outputs in one pass: the upper row forms the even part of the newer output and the odd part of the older output, and the lower row forms the other two parts. A one-entry unpacking stage releases the newer result one cycle after the older one. Changing the mode flushes all sample history. After a flush, the valid strobe stays low until enough samples have entered to fill the selected length.

Top module: `dual_len_fir`

## Requirements
- R1: After reset `y_valid_o` is 0, `y_data_o` is 0 and every coefficient is 0, so outputs computed before any coefficient write are 0.
- R2: In full mode (`half_mode_i`=0), the cycle after a sample is accepted, `y_data_o` holds the signed sum over k=0..N-1 of h(k)·x[n-k]. Here x[n] is that sample, and any sample older than the last flush counts as 0.
- R3: In full mode, `y_valid_o` is 1 exactly in the cycle after an accepted sample whose count since the last flush or reset is at least N.
- R4: In half mode (`half_mode_i`=1), samples pair in arrival order. The first sample of a pair produces no output. One cycle after the second sample, the result for the first sample appears, and the result for the second sample appears in the cycle after that. Each result is the sum over k=0..N/2-1 of h(k)·x[n-k].
- R5: In half mode, `y_valid_o` is 1 for a result only when the sample it belongs to has a count since the last flush of at least N/2.
- R6: In half mode, coefficients h(N/2)..h(N-1) have no effect on any output.
- R7: A cycle in which `half_mode_i` differs from the active mode flushes the block. It clears both delay lines, any unpaired sample, any pending second result and the fill count, and it drops a sample presented in that cycle. The next cycle has `y_valid_o`=0.
- R8: A coefficient write to index `coef_addr_i` is used for samples accepted from the following cycle on. A sample accepted in the same cycle as the write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_mode_i | input | 1 | 0 selects N taps, 1 selects N/2 taps |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | $clog2(N) | Coefficient index k |
| coef_data_i | input | CW | Signed coefficient value |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_data_i | input | DW | Signed input sample |
| y_valid_o | output | 1 | Output sample strobe |
| y_data_o | output | DW+CW+$clog2(N) | Signed filter output |

## Verification
A wrong shift route or a wrong operand select in either delay line corrupts `y_data_o` in the first cycle in which an affected tap contributes to a sum. An impulse followed by random data exposes it within N/2 or N samples. An error in the pairing or unpacking stage swaps or drops a result, or shifts the valid strobe by one cycle. This shows at the output one or two cycles after a pair completes. A stale coefficient or a fill count that is not cleared shows up as a valid strobe that rises too early, or as a wrong sum, right after a mode switch. A cycle-accurate behavioural model compares the valid strobe on every cycle and the data whenever it is valid.

// File: rtl/dlf_pkg.sv
package dlf_pkg;

    typedef enum logic {
        LEN_FULL = 1'b0,
        LEN_HALF = 1'b1
    } len_mode_e;

endpackage

// File: rtl/dlf_tap_line.sv
module dlf_tap_line #(
    parameter int LEN = 8,
    parameter int DW  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_i,
    input  logic                    adv_i,
    input  logic                    dbl_i,
    input  logic [DW-1:0]           new0_i,
    input  logic [DW-1:0]           new1_i,
    output logic [LEN-1:0][DW-1:0]  taps_o
);

    logic [LEN-1:0][DW-1:0] taps_d, taps_q;

    always_comb begin
        taps_d = taps_q;
        if (clear_i) begin
            taps_d = '0;
        end else if (adv_i) begin
            taps_d[0] = new0_i;
            if (dbl_i) begin
                taps_d[1] = new1_i;
                for (int i = 2; i < LEN; i++) begin
                    taps_d[i] = taps_q[i-2];
                end
            end else begin
                for (int i = 1; i < LEN; i++) begin
                    taps_d[i] = taps_q[i-1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q <= '0;
        end else begin
            taps_q <= taps_d;
        end
    end

    assign taps_o = taps_q;

endmodule

// File: rtl/dlf_product_row.sv
module dlf_product_row #(
    parameter int TAPS = 8,
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int OW   = 36
) (
    input  logic [TAPS-1:0][DW-1:0] smp_i,
    input  logic [TAPS-1:0][CW-1:0] cof_i,
    output logic signed [OW-1:0]    even_sum_o,
    output logic signed [OW-1:0]    odd_sum_o
);

    localparam int PW = DW + CW;

    logic signed [OW-1:0] prod [TAPS];

    for (genvar j = 0; j < TAPS; j++) begin : g_mul
        logic signed [PW-1:0] raw;
        assign raw     = $signed(smp_i[j]) * $signed(cof_i[j]);
        assign prod[j] = OW'(raw);
    end

    always_comb begin
        even_sum_o = '0;
        odd_sum_o  = '0;
        for (int i = 0; i < TAPS; i += 2) begin
            even_sum_o = even_sum_o + prod[i];
            odd_sum_o  = odd_sum_o + prod[i+1];
        end
    end

endmodule

// File: rtl/dual_len_fir.sv
module dual_len_fir
    import dlf_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          half_mode_i,
    input  logic                          coef_we_i,
    input  logic [$clog2(N)-1:0]          coef_addr_i,
    input  logic [CW-1:0]                 coef_data_i,
    input  logic                          smp_valid_i,
    input  logic [DW-1:0]                 smp_data_i,
    output logic                          y_valid_o,
    output logic [DW+CW+$clog2(N)-1:0]    y_data_o
);

    localparam int H    = N / 2;
    localparam int OW   = DW + CW + $clog2(N);
    localparam int CNTW = $clog2(N + 1);
    localparam logic [CNTW-1:0] FILL_MAX  = CNTW'(N);
    localparam logic [CNTW-1:0] FULL_LAST = CNTW'(N - 1);
    localparam logic [CNTW-1:0] HALF_LEN  = CNTW'(H);

    typedef struct packed {
        len_mode_e              act_mode;
        logic                   spc_have;
        logic [DW-1:0]          spc_smp;
        logic                   psc_pend;
        logic                   psc_vld;
        logic [OW-1:0]          psc_val;
        logic                   out_vld;
        logic [OW-1:0]          out_val;
        logic [CNTW-1:0]        fill;
        logic [N-1:0][CW-1:0]   coef;
    } fir_state_t;

    fir_state_t st_d, st_q;

    logic is_half, flush, accept, line_adv;
    logic [H-1:0][DW-1:0]   up_taps;
    logic [H-2:0][DW-1:0]   lo_taps;
    logic [DW-1:0]          lo_new0;
    logic [N-1:0][DW-1:0]   xf;
    logic [H:0][DW-1:0]     xh;
    logic [H-1:0][DW-1:0]   top_smp, bot_smp;
    logic [H-1:0][CW-1:0]   top_cof, bot_cof;
    logic signed [OW-1:0]   top_even, top_odd, bot_even, bot_odd;
    logic signed [OW-1:0]   full_sum, y_new, y_old;

    // control decode
    assign is_half  = (st_q.act_mode == LEN_HALF);
    assign flush    = (st_q.act_mode != len_mode_e'(half_mode_i));
    assign accept   = smp_valid_i && !flush;
    assign line_adv = accept && (!is_half || st_q.spc_have);
    assign lo_new0  = is_half ? up_taps[H-2] : up_taps[H-1];

    // two tapped delay lines; the lower one is fed from the upper tail
    dlf_tap_line #(.LEN(H), .DW(DW)) u_up_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (flush),
        .adv_i   (line_adv),
        .dbl_i   (is_half),
        .new0_i  (smp_data_i),
        .new1_i  (st_q.spc_smp),
        .taps_o  (up_taps)
    );

    dlf_tap_line #(.LEN(H-1), .DW(DW)) u_lo_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (flush),
        .adv_i   (line_adv),
        .dbl_i   (is_half),
        .new0_i  (lo_new0),
        .new1_i  (up_taps[H-1]),
        .taps_o  (lo_taps)
    );

    // sample windows: xf[k] = x[n-k] for N taps, xh[k] = x[n-k] for a pair
    for (genvar k = 0; k < N; k++) begin : g_xf
        if (k == 0) begin : g_now
            assign xf[k] = smp_data_i;
        end else if (k <= H) begin : g_up
            assign xf[k] = up_taps[k-1];
        end else begin : g_lo
            assign xf[k] = lo_taps[k-1-H];
        end
    end

    for (genvar k = 0; k <= H; k++) begin : g_xh
        if (k == 0) begin : g_now
            assign xh[k] = smp_data_i;
        end else if (k == 1) begin : g_pair
            assign xh[k] = st_q.spc_smp;
        end else begin : g_up
            assign xh[k] = up_taps[k-2];
        end
    end

    // operand routing per multiplier column
    for (genvar j = 0; j < H; j++) begin : g_route
        assign top_smp[j] = is_half ? xh[j + (j % 2)] : xf[j];
        assign bot_smp[j] = is_half ? xh[j + 1 - (j % 2)] : xf[H + j];
        assign top_cof[j] = st_q.coef[j];
        assign bot_cof[j] = is_half ? st_q.coef[j] : st_q.coef[H + j];
    end

    dlf_product_row #(.TAPS(H), .DW(DW), .CW(CW), .OW(OW)) u_top_row (
        .smp_i      (top_smp),
        .cof_i      (top_cof),
        .even_sum_o (top_even),
        .odd_sum_o  (top_odd)
    );

    dlf_product_row #(.TAPS(H), .DW(DW), .CW(CW), .OW(OW)) u_bot_row (
        .smp_i      (bot_smp),
        .cof_i      (bot_cof),
        .even_sum_o (bot_even),
        .odd_sum_o  (bot_odd)
    );

    // recombination of the four partial sums
    assign full_sum = (top_even + top_odd) + (bot_even + bot_odd);
    assign y_new    = top_even + bot_odd;
    assign y_old    = bot_even + top_odd;

    always_comb begin
        st_d         = st_q;
        st_d.out_vld = 1'b0;

        if (coef_we_i) begin
            st_d.coef[coef_addr_i] = coef_data_i;
        end

        if (flush) begin
            st_d.act_mode = len_mode_e'(half_mode_i);
            st_d.spc_have = 1'b0;
            st_d.psc_pend = 1'b0;
            st_d.psc_vld  = 1'b0;
            st_d.fill     = '0;
        end else begin
            if (st_q.psc_pend) begin
                st_d.out_vld  = st_q.psc_vld;
                st_d.out_val  = st_q.psc_val;
                st_d.psc_pend = 1'b0;
            end
            if (accept) begin
                if (st_q.fill != FILL_MAX) begin
                    st_d.fill = st_q.fill + 1'b1;
                end
                if (!is_half) begin
                    st_d.out_vld = (st_q.fill >= FULL_LAST);
                    st_d.out_val = full_sum;
                end else if (!st_q.spc_have) begin
                    st_d.spc_have = 1'b1;
                    st_d.spc_smp  = smp_data_i;
                end else begin
                    st_d.spc_have = 1'b0;
                    st_d.out_vld  = (st_q.fill >= HALF_LEN);
                    st_d.out_val  = y_old;
                    st_d.psc_pend = 1'b1;
                    st_d.psc_vld  = (st_q.fill >= HALF_LEN - 1'b1);
                    st_d.psc_val  = y_new;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_valid_o = st_q.out_vld;
    assign y_data_o  = st_q.out_val;

endmodule

// File: rtl/dlf_checker.sv
module dlf_checker #(
    parameter int N = 16
) (
    input logic clk,
    input logic rst_n,
    input logic half_mode_i,
    input logic smp_valid_i,
    input logic y_valid_o,
    input logic act_half,
    input logic psc_pend
);

    localparam int unsigned H = N / 2;

    int unsigned seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 0;
        end else if (half_mode_i != act_half) begin
            seen_q <= 0;
        end else if (smp_valid_i && seen_q < N) begin
            seen_q <= seen_q + 1;
        end
    end

    // R3 R5
    fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid_o |-> (seen_q >= (act_half ? H : N)));

    // R4
    out_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid_o |-> ($past(smp_valid_i) || $past(psc_pend)));

    // R7
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_mode_i != act_half) |=> (!y_valid_o && !psc_pend));

    // R4
    psc_full_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_half |-> !psc_pend);

    // R4
    psc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_pend |=> !psc_pend);

endmodule

bind dual_len_fir dlf_checker #(.N(N)) u_dlf_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_mode_i (half_mode_i),
    .smp_valid_i (smp_valid_i),
    .y_valid_o   (y_valid_o),
    .act_half    (st_q.act_mode == dlf_pkg::LEN_HALF),
    .psc_pend    (st_q.psc_pend)
);

// File: tb/dual_len_fir_test.sv
module dual_len_fir_test;

    localparam int N = 16;
    localparam int H = N / 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        half_mode_i;
    logic        coef_we_i;
    logic [3:0]  coef_addr_i;
    logic [15:0] coef_data_i;
    logic        smp_valid_i;
    logic [15:0] smp_data_i;
    logic        y_valid_o;
    logic [35:0] y_data_o;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    bit     m_half = 0;
    int     m_cnt  = 0;
    longint m_hist [N];
    longint m_coef [N];
    bit     m_spc_have = 0;
    longint m_spc = 0;
    bit     m_psc_pend = 0;
    bit     m_psc_v = 0;
    longint m_psc_val = 0;
    bit     cur_half = 0;

    always #5 clk = ~clk;

    dual_len_fir uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .half_mode_i (half_mode_i),
        .coef_we_i   (coef_we_i),
        .coef_addr_i (coef_addr_i),
        .coef_data_i (coef_data_i),
        .smp_valid_i (smp_valid_i),
        .smp_data_i  (smp_data_i),
        .y_valid_o   (y_valid_o),
        .y_data_o    (y_data_o)
    );

    task automatic push_hist(input longint v);
        for (int i = N - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
        m_hist[0] = v;
    endtask

    task automatic model(input bit v, input longint d, input bit we, input int a,
                         input longint cd, output bit ev, output longint ed);
        longint s, so;
        ev = 0;
        ed = 0;
        if (cur_half != m_half) begin
            for (int i = 0; i < N; i++) m_hist[i] = 0;
            m_cnt = 0;
            m_spc_have = 0;
            m_psc_pend = 0;
            m_half = cur_half;
        end else begin
            if (m_psc_pend) begin
                ev = m_psc_v;
                ed = m_psc_val;
                m_psc_pend = 0;
            end
            if (v) begin
                if (!m_half) begin
                    s = m_coef[0] * d;
                    for (int k = 1; k < N; k++) s += m_coef[k] * m_hist[k-1];
                    ev = (m_cnt + 1 >= N);
                    ed = s;
                    push_hist(d);
                    if (m_cnt < N) m_cnt++;
                end else if (!m_spc_have) begin
                    m_spc_have = 1;
                    m_spc = d;
                    if (m_cnt < N) m_cnt++;
                end else begin
                    s  = m_coef[0] * d + m_coef[1] * m_spc;
                    for (int k = 2; k < H; k++) s += m_coef[k] * m_hist[k-2];
                    so = m_coef[0] * m_spc;
                    for (int k = 1; k < H; k++) so += m_coef[k] * m_hist[k-1];
                    ev = (m_cnt >= H);
                    ed = so;
                    m_psc_pend = 1;
                    m_psc_v = (m_cnt + 1 >= H);
                    m_psc_val = s;
                    push_hist(m_spc);
                    push_hist(d);
                    m_spc_have = 0;
                    if (m_cnt < N) m_cnt++;
                end
            end
        end
        if (we) m_coef[a] = cd;
    endtask

    task automatic cyc(input bit v, input int d, input bit we, input int a,
                       input int cd, input string tag);
        bit     ev;
        longint ed;
        longint act;
        @(negedge clk);
        smp_valid_i = v;
        smp_data_i  = 16'(d);
        coef_we_i   = we;
        coef_addr_i = 4'(a);
        coef_data_i = 16'(cd);
        half_mode_i = cur_half;
        model(v, longint'(d), we, a, longint'(cd), ev, ed);
        @(posedge clk);
        #1;
        act = longint'($signed(y_data_o));
        checks++;
        if (y_valid_o !== ev) begin
            fails++;
            $display("FAIL %s valid actual=%0b expected=%0b", tag, y_valid_o, ev);
        end else if (ev && act != ed) begin
            fails++;
            $display("FAIL %s data actual=%0d expected=%0d", tag, act, ed);
        end
    endtask

    function automatic int rnd_smp();
        return int'($urandom_range(0, 65535)) - 32768;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(7));
        for (int i = 0; i < N; i++) begin
            m_hist[i] = 0;
            m_coef[i] = 0;
        end
        rst_n = 1'b0;
        half_mode_i = 1'b0;
        coef_we_i = 1'b0;
        coef_addr_i = '0;
        coef_data_i = '0;
        smp_valid_i = 1'b0;
        smp_data_i = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values
        checks++;
        if (y_valid_o !== 1'b0) begin
            fails++;
            $display("FAIL R1 valid actual=%0b expected=0", y_valid_o);
        end
        checks++;
        if (y_data_o !== '0) begin
            fails++;
            $display("FAIL R1 data actual=%0d expected=0", y_data_o);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: zero coefficients give zero sums
        for (int i = 0; i < 20; i++) cyc(1, rnd_smp(), 0, 0, 0, "R1");

        // R8: load coefficients, with both extremes present
        for (int k = 0; k < N; k++)
            cyc(0, 0, 1, k, (k == 5) ? -32768 : (k == 9) ? 32767 : k * 37 - 250, "R8");

        // R2: impulse response
        cyc(1, 1000, 0, 0, 0, "R2");
        for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0, "R2");
        // R3: random data with gaps
        for (int i = 0; i < 60; i++)
            cyc(($urandom_range(0, 3) != 0), rnd_smp(), 0, 0, 0, "R3");

        // R8: writes in the same cycle as samples
        for (int i = 0; i < 12; i++)
            cyc(1, rnd_smp(), 1, (i * 5) % N, rnd_smp(), "R8");

        // R2: largest magnitude sum
        for (int k = 0; k < N; k++) cyc(0, 0, 1, k, -32768, "R2");
        for (int i = 0; i < 20; i++) cyc(1, -32768, 0, 0, 0, "R2");
        for (int k = 0; k < N; k++) cyc(0, 0, 1, k, rnd_smp(), "R8");

        // R7: switch to half length
        cur_half = 1;
        cyc(0, 0, 0, 0, 0, "R7");
        // R5 fill, then R4 paired streaming with gaps
        for (int i = 0; i < 12; i++) cyc(1, rnd_smp(), 0, 0, 0, "R5");
        for (int i = 0; i < 50; i++)
            cyc(($urandom_range(0, 2) != 0), rnd_smp(), 0, 0, 0, "R4");

        // R6: rewrite the unused upper coefficients while streaming
        for (int i = 0; i < 24; i++)
            cyc(1, rnd_smp(), (i < H), H + (i % H), rnd_smp(), "R6");

        // R7: leave an unpaired sample, then switch with a sample present
        cyc(1, 1234, 0, 0, 0, "R7");
        cur_half = 0;
        cyc(1, 4321, 0, 0, 0, "R7");
        for (int i = 0; i < 24; i++) cyc(1, rnd_smp(), 0, 0, 0, "R3");

        // R7: back to half length right after a full result
        cur_half = 1;
        cyc(1, 777, 0, 0, 0, "R7");
        for (int i = 0; i < 30; i++) cyc(1, rnd_smp(), 0, 0, 0, "R4");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, "R4");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule